// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit logical address into a physical address in two steps. The segment number selects one of sixteen descriptors held in a local register file. Each descriptor holds the physical base of that segment's page table, the number of valid entries in that table, and read and write permissions for the whole segment. The page number is checked against that count. Only when it is in range does the block fetch the page table entry over a simple memory-read handshake.

The fetched entry supplies a frame number, a present flag and its own read and write flags. If every check passes, the block returns the frame joined to the untouched page offset. If a check fails, it returns a two-bit cause code instead. Descriptors are loaded through a separate write port. One translation is in flight at a time, and a busy flag covers it from acceptance to completion.

Top module: `seg_xlate_top`

## Requirements
- R1: The logical address `req_addr` is split as segment = bits [23:20], page = bits [19:12] and offset = bits [11:0].
- R2: When `dsc_we` is high at a clock edge, descriptor `dsc_idx` takes `dsc_base`, `dsc_limit`, `dsc_rd_ok` and `dsc_wr_ok`. Reset clears every limit to 0, so every page of every segment is then out of range.
- R3: If the page number is greater than or equal to the segment's limit, the block never raises `mem_req`. It raises `done` with `fault`=1 and `fault_code`=0 in the cycle after acceptance.
- R4: The entry address on `mem_addr` is the segment base plus page × 4. `mem_req` stays high with a stable `mem_addr` until `mem_valid` is sampled high.
- R5: The entry on `mem_rdata` is 15 bits wide: bit 14 = present, bit 13 = write allowed, bit 12 = read allowed, bits [11:0] = frame. An entry whose present bit is 0 gives `fault_code`=1. This cause takes priority over both permission causes.
- R6: A write (`req_write`=1) to a present page needs write permission in both the segment and the entry. Without it, the result is `fault_code`=2.
- R7: A read to a present page needs read permission in both the segment and the entry. Without it, the result is `fault_code`=3.
- R8: A translation that passes every check gives `fault`=0 and `phys_addr` = {frame, offset}, with the offset unchanged. `done` rises in the cycle after `mem_valid` is sampled.
- R9: A request is accepted only when `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse. A request raised while busy is ignored.
- R10: On a fault, `phys_addr` reads 0 during the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsc_we | input | 1 | Descriptor write strobe |
| dsc_idx | input | 4 | Descriptor index to write |
| dsc_base | input | 24 | Physical base of the segment's page table |
| dsc_limit | input | 9 | Number of valid entries (0..256) |
| dsc_rd_ok | input | 1 | Segment allows reads |
| dsc_wr_ok | input | 1 | Segment allows writes |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write access |
| req_addr | input | 24 | Logical address |
| busy | output | 1 | Translation in progress |
| mem_req | output | 1 | Page table entry read request |
| mem_addr | output | 24 | Byte address of the entry |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 15 | Page table entry |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Result is a fault |
| fault_code | output | 2 | Fault cause (0 bound, 1 absent, 2 write, 3 read) |
| phys_addr | output | 24 | Physical address |

## Verification
The bound checker tests the handshake rules on every cycle. While waiting, the entry request holds with a steady, word-aligned address. `done` is a single pulse that falls inside `busy`, and an accepted request raises `busy`. A faulting result carries a zero address, and a good result keeps the offset of the accepted request. A bound fault never shows a memory read. Only the bench scenarios can show the following. The entry address arithmetic must match the descriptor that was loaded. Each fault cause must be chosen correctly from the entry and segment flags, and the not-present cause must win when several apply. A request raised mid-translation must be dropped, and reset must leave every segment empty.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_RESP} xl_state_e;

    typedef enum logic [1:0] {
        FC_BOUND  = 2'd0,
        FC_ABSENT = 2'd1,
        FC_WPROT  = 2'd2,
        FC_RPROT  = 2'd3
    } fault_code_e;

    // Entry flag positions above the frame field
    localparam int PTE_FLAGS   = 3;
    localparam int ENTRY_SHIFT = 2;   // 4-byte entries
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
    parameter int SEG_W  = 4,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  widx,
    input  logic [BASE_W-1:0] wbase,
    input  logic [LIM_W-1:0]  wlim,
    input  logic              wrd,
    input  logic              wwr,
    input  logic [SEG_W-1:0]  ridx,
    output logic [BASE_W-1:0] rbase,
    output logic [LIM_W-1:0]  rlim,
    output logic              rrd,
    output logic              rwr
);
    localparam int NSEG = 1 << SEG_W;

    logic [BASE_W-1:0] base_q [NSEG];
    logic [LIM_W-1:0]  lim_q  [NSEG];
    logic [NSEG-1:0]   rd_q;
    logic [NSEG-1:0]   wr_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                lim_q[g]  <= '0;
                rd_q[g]   <= 1'b0;
                wr_q[g]   <= 1'b0;
            end else if (we && (widx == SEG_W'(g))) begin
                base_q[g] <= wbase;
                lim_q[g]  <= wlim;
                rd_q[g]   <= wrd;
                wr_q[g]   <= wwr;
            end
        end
    end

    assign rbase = base_q[ridx];
    assign rlim  = lim_q[ridx];
    assign rrd   = rd_q[ridx];
    assign rwr   = wr_q[ridx];
endmodule

// File: rtl/seg_pte_check.sv
module seg_pte_check
    import seg_xlate_pkg::*;
#(
    parameter int FRAME_W = 12
) (
    input  logic [FRAME_W+PTE_FLAGS-1:0] pte,
    input  logic                         is_write,
    input  logic                         seg_rd,
    input  logic                         seg_wr,
    output logic                         flt,
    output logic [1:0]                   code,
    output logic [FRAME_W-1:0]           frame
);
    logic present, pg_wr, pg_rd;

    always_comb begin
        present = pte[FRAME_W+2];
        pg_wr   = pte[FRAME_W+1];
        pg_rd   = pte[FRAME_W];
        frame   = pte[FRAME_W-1:0];
        flt     = 1'b1;
        code    = FC_ABSENT;
        if (!present) begin
            code = FC_ABSENT;
        end else if (is_write && !(seg_wr && pg_wr)) begin
            code = FC_WPROT;
        end else if (!is_write && !(seg_rd && pg_rd)) begin
            code = FC_RPROT;
        end else begin
            flt  = 1'b0;
            code = FC_BOUND;
        end
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12,
    parameter int PA_W    = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            dsc_we,
    input  logic [SEG_W-1:0]                dsc_idx,
    input  logic [PA_W-1:0]                 dsc_base,
    input  logic [PAGE_W:0]                 dsc_limit,
    input  logic                            dsc_rd_ok,
    input  logic                            dsc_wr_ok,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0]   req_addr,
    output logic                            busy,
    output logic                            mem_req,
    output logic [PA_W-1:0]                 mem_addr,
    input  logic                            mem_valid,
    input  logic [FRAME_W+PTE_FLAGS-1:0]    mem_rdata,
    output logic                            done,
    output logic                            fault,
    output logic [1:0]                      fault_code,
    output logic [FRAME_W+OFF_W-1:0]        phys_addr
);
    localparam int LA_W   = SEG_W + PAGE_W + OFF_W;
    localparam int PHYS_W = FRAME_W + OFF_W;
    localparam int LIM_W  = PAGE_W + 1;

    typedef struct packed {
        xl_state_e          st;
        logic               wr;
        logic               seg_rd;
        logic               seg_wr;
        logic [OFF_W-1:0]   off;
        logic [PA_W-1:0]    maddr;
        logic               flt;
        logic [1:0]         code;
        logic [PHYS_W-1:0]  pa;
    } xl_reg_t;

    xl_reg_t r_q, r_d;

    // Address fields (R1)
    logic [SEG_W-1:0]  a_seg;
    logic [PAGE_W-1:0] a_page;
    logic [OFF_W-1:0]  a_off;
    assign a_seg  = req_addr[LA_W-1 -: SEG_W];
    assign a_page = req_addr[OFF_W +: PAGE_W];
    assign a_off  = req_addr[OFF_W-1:0];

    logic [PA_W-1:0]  d_base;
    logic [LIM_W-1:0] d_lim;
    logic             d_rd, d_wr;

    seg_desc_file #(.SEG_W(SEG_W), .BASE_W(PA_W), .LIM_W(LIM_W)) u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dsc_we),
        .widx  (dsc_idx),
        .wbase (dsc_base),
        .wlim  (dsc_limit),
        .wrd   (dsc_rd_ok),
        .wwr   (dsc_wr_ok),
        .ridx  (a_seg),
        .rbase (d_base),
        .rlim  (d_lim),
        .rrd   (d_rd),
        .rwr   (d_wr)
    );

    logic               c_flt;
    logic [1:0]         c_code;
    logic [FRAME_W-1:0] c_frame;

    seg_pte_check #(.FRAME_W(FRAME_W)) u_chk_pte (
        .pte      (mem_rdata),
        .is_write (r_q.wr),
        .seg_rd   (r_q.seg_rd),
        .seg_wr   (r_q.seg_wr),
        .flt      (c_flt),
        .code     (c_code),
        .frame    (c_frame)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.wr     = req_write;
                    r_d.seg_rd = d_rd;
                    r_d.seg_wr = d_wr;
                    r_d.off    = a_off;
                    if ({1'b0, a_page} >= d_lim) begin
                        r_d.st   = ST_RESP;
                        r_d.flt  = 1'b1;
                        r_d.code = FC_BOUND;
                        r_d.pa   = '0;
                    end else begin
                        r_d.st    = ST_MEM;
                        r_d.maddr = d_base + (PA_W'(a_page) << ENTRY_SHIFT);
                    end
                end
            end
            ST_MEM: begin
                if (mem_valid) begin
                    r_d.st   = ST_RESP;
                    r_d.flt  = c_flt;
                    r_d.code = c_code;
                    r_d.pa   = c_flt ? '0 : {c_frame, r_q.off};
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign mem_req    = (r_q.st == ST_MEM);
    assign done       = (r_q.st == ST_RESP);
    assign mem_addr   = r_q.maddr;
    assign fault      = r_q.flt;
    assign fault_code = r_q.code;
    assign phys_addr  = r_q.pa;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int OFF_W  = 12,
    parameter int PHYS_W = 24,
    parameter int PA_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OFF_W-1:0]  req_off,
    input logic              busy,
    input logic              mem_req,
    input logic [PA_W-1:0]   mem_addr,
    input logic              mem_valid,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_code,
    input logic [PHYS_W-1:0] phys_addr
);
    logic [OFF_W-1:0] off_cap;
    logic             mem_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cap  <= '0;
            mem_seen <= 1'b0;
        end else if (req_valid && !busy) begin
            off_cap  <= req_off;
            mem_seen <= 1'b0;
        end else if (mem_req) begin
            mem_seen <= 1'b1;
        end
    end

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
    a_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (phys_addr == '0));
    a_r8_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (phys_addr[OFF_W-1:0] == off_cap));
    a_r3_bound_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code == 2'd0) |-> !mem_seen);
endmodule

bind seg_xlate_top seg_xlate_chk #(
    .OFF_W  (OFF_W),
    .PHYS_W (FRAME_W + OFF_W),
    .PA_W   (PA_W)
) u_xlate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_off    (req_addr[OFF_W-1:0]),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .phys_addr  (phys_addr)
);

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dsc_we = 1'b0;
    logic [3:0]  dsc_idx = '0;
    logic [23:0] dsc_base = '0;
    logic [8:0]  dsc_limit = '0;
    logic        dsc_rd_ok = 1'b0, dsc_wr_ok = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic        busy, mem_req, done, fault;
    logic [23:0] mem_addr, phys_addr;
    logic        mem_valid = 1'b0;
    logic [14:0] mem_rdata = '0;
    logic [1:0]  fault_code;

    always #10 clk = ~clk;   // 50 MHz

    seg_xlate_top dut (
        .clk(clk), .rst_n(rst_n), .dsc_we(dsc_we), .dsc_idx(dsc_idx),
        .dsc_base(dsc_base), .dsc_limit(dsc_limit), .dsc_rd_ok(dsc_rd_ok),
        .dsc_wr_ok(dsc_wr_ok), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_code(fault_code), .phys_addr(phys_addr)
    );

    int checks = 0;
    int errors = 0;

    logic [23:0] tb_base [16];

    // Results of the last translation
    logic        res_mem, res_done, res_fault, res_busy, res_after_done, res_after_busy;
    logic [1:0]  res_code;
    logic [23:0] res_pa, res_maddr;
    int          res_cyc, res_feed;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_desc(input logic [3:0] idx, input logic [23:0] base,
                             input logic [8:0] lim, input logic rd, input logic wr);
        @(negedge clk);
        dsc_we = 1'b1; dsc_idx = idx; dsc_base = base; dsc_limit = lim;
        dsc_rd_ok = rd; dsc_wr_ok = wr;
        tb_base[idx] = base;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    task automatic xlate(input logic wr, input logic [23:0] a, input logic [14:0] pte,
                         input int wt, input bit stray);
        int cyc = 0;
        int wcnt = 0;
        res_mem = 1'b0; res_feed = -1; res_maddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 200) begin
            if (mem_req) begin
                if (!res_mem) begin res_mem = 1'b1; res_maddr = mem_addr; end
                if (wcnt == wt) begin mem_valid = 1'b1; mem_rdata = pte; res_feed = cyc; end
                wcnt++;
                if (stray && wcnt == 2) begin req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h100000; end
            end
            @(negedge clk);
            mem_valid = 1'b0; req_valid = 1'b0; cyc++;
        end
        res_cyc = cyc; res_done = done; res_fault = fault; res_code = fault_code;
        res_pa = phys_addr; res_busy = busy;
        @(negedge clk);
        res_after_done = done; res_after_busy = busy;
    endtask

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [14:0] pte;
        logic [3:0]  wt;
        logic        exp_mem;
        logic        exp_flt;
        logic [1:0]  exp_code;
        logic [23:0] exp_pa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h002016, 15'h701f, 4'd0, 1'b1, 1'b0, 2'd0, 24'h01f016},
        '{1'b1, 24'h003100, 15'h7011, 4'd2, 1'b1, 1'b1, 2'd2, 24'h000000},
        '{1'b0, 24'h100abc, 15'h0000, 4'd0, 1'b0, 1'b1, 2'd0, 24'h000000},
        '{1'b0, 24'h20d000, 15'h7001, 4'd0, 1'b0, 1'b1, 2'd0, 24'h000000},
        '{1'b0, 24'h20cfff, 15'h77ab, 4'd3, 1'b1, 1'b0, 2'd0, 24'h7abfff},
        '{1'b1, 24'h201444, 15'h3003, 4'd1, 1'b1, 1'b1, 2'd1, 24'h000000},
        '{1'b1, 24'h202555, 15'h5004, 4'd0, 1'b1, 1'b1, 2'd2, 24'h000000},
        '{1'b0, 24'h204666, 15'h6005, 4'd0, 1'b1, 1'b1, 2'd3, 24'h000000},
        '{1'b0, 24'h3ff123, 15'h5fff, 4'd1, 1'b1, 1'b0, 2'd0, 24'hfff123},
        '{1'b0, 24'h400777, 15'h7001, 4'd0, 1'b1, 1'b1, 2'd3, 24'h000000},
        '{1'b1, 24'h401000, 15'h70a5, 4'd2, 1'b1, 1'b0, 2'd0, 24'h0a5000},
        '{1'b1, 24'h203000, 15'h0000, 4'd0, 1'b1, 1'b1, 2'd1, 24'h000000}
    };

    task automatic check_result(input string req, input logic exp_mem, input logic exp_flt,
                                input logic [1:0] exp_code, input logic [23:0] exp_pa,
                                input logic [23:0] a);
        logic [23:0] exp_maddr;
        exp_maddr = tb_base[a[23:20]] + {14'd0, a[19:12], 2'b00};
        chk(res_done && res_busy, "R9", {req, " done within busy"}, {30'd0, res_done, res_busy}, 32'h3);
        chk(res_mem == exp_mem, exp_mem ? "R4" : "R3", {req, " memory read seen"}, res_mem, exp_mem);
        if (exp_mem) begin
            chk(res_maddr == exp_maddr, "R4", {req, " entry address"}, res_maddr, exp_maddr);
            chk(res_cyc == res_feed + 1, "R8", {req, " latency after mem_valid"}, res_cyc, res_feed + 1);
        end else begin
            chk(res_cyc == 0, "R3", {req, " bound fault latency"}, res_cyc, 0);
        end
        chk(res_fault == exp_flt, "R5", {req, " fault flag"}, res_fault, exp_flt);
        if (exp_flt) begin
            chk(res_code == exp_code, "R6", {req, " fault code (R3 R5 R6 R7)"}, res_code, exp_code);
            chk(res_pa == 24'h0, "R10", {req, " address on fault"}, res_pa, 0);
        end else begin
            chk(res_pa == exp_pa, "R8", {req, " physical address (R1)"}, res_pa, exp_pa);
        end
        chk(!res_after_done && !res_after_busy, "R9", {req, " one-cycle done then idle"},
            {30'd0, res_after_done, res_after_busy}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) tb_base[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R9", "reset state idle", {29'd0, busy, done, mem_req}, 0);
        rst_n = 1'b1;

        // R2: after reset every segment is empty
        xlate(1'b0, 24'h500123, 15'h7001, 0, 1'b0);
        check_result("R2 reset limits", 1'b0, 1'b1, 2'd0, 24'h0, 24'h500123);

        load_desc(4'd0, 24'h002000, 9'h014, 1'b1, 1'b0);
        load_desc(4'd1, 24'h000000, 9'h000, 1'b1, 1'b1);
        load_desc(4'd2, 24'h001000, 9'h00d, 1'b1, 1'b1);
        load_desc(4'd3, 24'h010000, 9'h100, 1'b1, 1'b1);
        load_desc(4'd4, 24'h020000, 9'h005, 1'b0, 1'b1);

        for (int v = 0; v < NV; v++) begin
            xlate(VECS[v].wr, VECS[v].addr, VECS[v].pte, int'(VECS[v].wt), 1'b0);
            check_result($sformatf("vec%0d", v), VECS[v].exp_mem, VECS[v].exp_flt,
                         VECS[v].exp_code, VECS[v].exp_pa, VECS[v].addr);
        end

        // R9: request raised while busy is dropped
        xlate(1'b0, 24'h205abc, 15'h7321, 4, 1'b1);
        check_result("R9 stray request", 1'b1, 1'b0, 2'd0, 24'h321abc, 24'h205abc);
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R9", "stray request not started", {30'd0, busy, done}, 0);

        // R2: rewriting a descriptor shrinks the bound
        load_desc(4'd2, 24'h001000, 9'h002, 1'b1, 1'b1);
        xlate(1'b0, 24'h202000, 15'h7001, 0, 1'b0);
        check_result("R2 rewritten limit", 1'b0, 1'b1, 2'd0, 24'h0, 24'h202000);
        xlate(1'b0, 24'h201008, 15'h7044, 0, 1'b0);
        check_result("R2 rewritten in range", 1'b1, 1'b0, 2'd0, 24'h044008, 24'h201008);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule